// File: doc/BRIEF.md
# SPDIF Slot Router with Validity Control

This block keeps a small audio control register and uses it to route two PCM slots of each AC-link frame to the left and right sub-frames of a SPDIF transmitter. Along with each routed sample it produces the sub-frame's audio word and validity flag. A two-bit mode, made of an external V bit and a padding-mode bit in the register, sets how the flag is formed and whether missing samples are replaced by zero. The register also drives the SPDIF output enable and a write permit for a neighbouring SPDIF control register.

A strap input is sampled once, on the first clock after reset is released. When the strap is high, SPDIF is unavailable. Every register bit except bit 0 then ignores writes and reads back as zero. The reset value of the slot-pair field depends on a two-bit codec ID.

Top module: `spdif_slot_router`

## Requirements
- R1: The slot-pair field (register bits 3:2) selects the left/right source slots: 00 gives slots 3/4, 01 gives 7/8, 10 gives 6/9, 11 gives 10/11.
- R2: After reset, bits 3:2 take 01 for codec ID 00, 10 for ID 01 or 10, and 11 for ID 11. All other register bits read 0, and bits 15:6 always read 0.
- R3: With the strap high at the first clock after reset, writes to bits 15:1 are ignored and those bits read 0. Bit 0 (rate enable) stays writable, and the output enable stays low. The strap value is held until the next reset.
- R4: spdif_oe equals register bit 1 (output enable). When it is 0, the SPDIF output is to be left in high impedance.
- R5: ctl_wr_ok is 1 exactly when the output enable is 0. It permits writes to every bit of the SPDIF control register except its bit 14.
- R6: With V=1 and padding mode (bit 4)=0, each sub-frame's validity flag equals int_err, and the audio word is the received slot data whatever its tag.
- R7: With V=0 and padding mode=1, a sub-frame whose source slot tag is 0 gets validity 0 and an all-zero word. A tagged sub-frame gets validity 0 and its slot data.
- R8: With V=0 and padding mode=0, validity is 0 and the slot data passes unchanged, whatever int_err and the tags are.
- R9: With V=1 and padding mode=1, validity equals int_err, and untagged sub-frames are zero-padded.
- R10: Bit 5 is a read-only status bit equal to output enable AND NOT (V AND padding mode). Writes to bit 5 have no effect.
- R11: On the clock edge where frame_end is high, the routed samples are captured. smp_stb is high for exactly the following cycle, and the sample outputs hold their values until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| codec_id | input | 2 | Codec ID, selects the slot-pair reset value |
| strap_in | input | 1 | SPDIF-disable strap, sampled once after reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register readback |
| frame_end | input | 1 | High for one cycle at the end of each AC-link frame |
| slot_tag | input | NUM_SLOTS | Per-slot valid tags of the frame |
| slot_data | input | NUM_SLOTS*SLOT_W | Slot data, slot k at bits k*SLOT_W upward |
| ext_v_bit | input | 1 | V bit from the SPDIF control register |
| int_err | input | 1 | Internal transmission error flag |
| smp_stb | output | 1 | One-cycle sample strobe |
| left_data | output | SLOT_W | Left sub-frame audio word |
| left_valid | output | 1 | Left sub-frame validity flag |
| right_data | output | SLOT_W | Right sub-frame audio word |
| right_valid | output | 1 | Right sub-frame validity flag |
| spdif_oe | output | 1 | SPDIF output enable |
| ctl_wr_ok | output | 1 | Write permit for the SPDIF control register |

## Verification
The bench builds the block with its defaults: thirteen slots of twenty bits. That covers every slot the four pairs can select, up to slot 11, and it leaves slots outside the selected pair whose data must never appear. Each slot carries a distinct full-width pattern, so a wrong pair choice, a swapped left/right or a missed zero-pad shows up as a word mismatch. The bench repeats reset under all four codec IDs and with the strap raised, so it reaches every reset value of the pair field and the locked readback.

// File: rtl/spdif_route_pkg.sv
// Shared encodings for the SPDIF slot router.
// Assumes: slot-pair codes and register bit positions are fixed by the
// neighbouring software-visible layout and must not be reordered.
package spdif_route_pkg;

    typedef enum logic [1:0] {
        PAIR_3_4   = 2'b00,
        PAIR_7_8   = 2'b01,
        PAIR_6_9   = 2'b10,
        PAIR_10_11 = 2'b11
    } pair_sel_t;

    localparam int REG_W    = 16;
    localparam int BIT_RATE = 0;
    localparam int BIT_OE   = 1;
    localparam int BIT_SEL  = 2;   // two bits, 3:2
    localparam int BIT_PAD  = 4;
    localparam int BIT_CFG  = 5;

    // Reset value of the pair field for a given codec ID.
    function automatic pair_sel_t reset_pair(input logic [1:0] cid);
        case (cid)
            2'b00:   return PAIR_7_8;
            2'b01:   return PAIR_6_9;
            2'b10:   return PAIR_6_9;
            default: return PAIR_10_11;
        endcase
    endfunction

    // Left source slot index for a pair code.
    function automatic logic [3:0] left_slot_of(input pair_sel_t p);
        case (p)
            PAIR_3_4:   return 4'd3;
            PAIR_7_8:   return 4'd7;
            PAIR_6_9:   return 4'd6;
            default:    return 4'd10;
        endcase
    endfunction

    // Right source slot index for a pair code.
    function automatic logic [3:0] right_slot_of(input pair_sel_t p);
        case (p)
            PAIR_3_4:   return 4'd4;
            PAIR_7_8:   return 4'd8;
            PAIR_6_9:   return 4'd9;
            default:    return 4'd11;
        endcase
    endfunction

endpackage

// File: rtl/xac_reg.sv
// Extended audio control register.
// Holds rate enable, output enable, slot pair and padding mode. It latches
// the strap once after reset; a high strap masks bits 15:1 to zero.
// Assumes: synchronous active-low reset; codec_id is stable during reset.
module xac_reg
    import spdif_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       codec_id,
    input  logic             strap_in,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             v_bit,
    output logic [REG_W-1:0] rd_data,
    output logic             out_en,
    output pair_sel_t        pair,
    output logic             pad_mode,
    output logic             locked
);

    logic      rate_q;
    logic      oe_q;
    pair_sel_t sel_q;
    logic      pad_q;
    logic      lock_q;
    logic      lock_done_q;
    logic      cfg_ok;
    logic      unused_hi;

    assign unused_hi = ^{wr_data[REG_W-1:BIT_CFG]};

    // Strap capture: one sample on the first clock after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q      <= 1'b0;
            lock_done_q <= 1'b0;
        end else if (!lock_done_q) begin
            lock_q      <= strap_in;
            lock_done_q <= 1'b1;
        end
    end

    // Field storage; bits 15:1 ignore writes once the strap locks them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= 1'b0;
            oe_q   <= 1'b0;
            sel_q  <= reset_pair(codec_id);
            pad_q  <= 1'b0;
        end else if (wr_en) begin
            rate_q <= wr_data[BIT_RATE];
            if (!lock_q) begin
                oe_q  <= wr_data[BIT_OE];
                sel_q <= pair_sel_t'(wr_data[BIT_SEL +: 2]);
                pad_q <= wr_data[BIT_PAD];
            end
        end
    end

    // Effective fields and readback, masked while locked.
    always_comb begin
        out_en   = oe_q & ~lock_q;
        pair     = lock_q ? PAIR_3_4 : sel_q;
        pad_mode = pad_q & ~lock_q;
        locked   = lock_q;
        cfg_ok   = out_en & ~(v_bit & pad_mode);
        rd_data  = '0;
        rd_data[BIT_RATE]     = rate_q;
        rd_data[BIT_OE]       = out_en;
        rd_data[BIT_SEL +: 2] = lock_q ? 2'b00 : sel_q;
        rd_data[BIT_PAD]      = pad_mode;
        rd_data[BIT_CFG]      = cfg_ok;
    end

endmodule

// File: rtl/slot_pick.sv
// Slot pair multiplexer: selects left and right slot data and tags.
// Assumes: NUM_SLOTS covers slot 11 at least; purely combinational.
module slot_pick
    import spdif_route_pkg::*;
#(
    parameter int NUM_SLOTS = 13,
    parameter int SLOT_W    = 20
) (
    input  pair_sel_t                    pair,
    input  logic [NUM_SLOTS-1:0]         slot_tag,
    input  logic [NUM_SLOTS*SLOT_W-1:0]  slot_data,
    output logic [SLOT_W-1:0]            l_data,
    output logic                         l_tag,
    output logic [SLOT_W-1:0]            r_data,
    output logic                         r_tag
);

    localparam int IDX_W = $clog2(NUM_SLOTS);

    logic [SLOT_W-1:0] slot_arr [NUM_SLOTS];
    logic [IDX_W-1:0]  l_idx;
    logic [IDX_W-1:0]  r_idx;

    // Unpack the flat slot bus into an indexed array.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_unpack
        assign slot_arr[g] = slot_data[g*SLOT_W +: SLOT_W];
    end

    // Index lookup and selection.
    always_comb begin
        l_idx  = IDX_W'(left_slot_of(pair));
        r_idx  = IDX_W'(right_slot_of(pair));
        l_data = slot_arr[l_idx];
        l_tag  = slot_tag[l_idx];
        r_data = slot_arr[r_idx];
        r_tag  = slot_tag[r_idx];
    end

endmodule

// File: rtl/subframe_fmt.sv
// Forms one sub-frame's audio word and validity flag from the mode bits.
// Assumes: v_bit gates error reporting, pad_mode zero-fills untagged slots.
module subframe_fmt #(
    parameter int SLOT_W = 20
) (
    input  logic              v_bit,
    input  logic              pad_mode,
    input  logic              int_err,
    input  logic              tag,
    input  logic [SLOT_W-1:0] data_in,
    output logic [SLOT_W-1:0] word,
    output logic              vflag
);

    // Padding and flag rule.
    always_comb begin
        word  = (pad_mode && !tag) ? '0 : data_in;
        vflag = v_bit & int_err;
    end

endmodule

// File: rtl/spdif_slot_router.sv
// Top: control register, slot pair selection, sub-frame formatting and
// the capture register that presents samples with a one-cycle strobe.
// Assumes: frame_end is a single-cycle pulse with slot_tag/slot_data valid.
module spdif_slot_router
    import spdif_route_pkg::*;
#(
    parameter int NUM_SLOTS = 13,
    parameter int SLOT_W    = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  codec_id,
    input  logic                        strap_in,
    input  logic                        wr_en,
    input  logic [15:0]                 wr_data,
    output logic [15:0]                 rd_data,
    input  logic                        frame_end,
    input  logic [NUM_SLOTS-1:0]        slot_tag,
    input  logic [NUM_SLOTS*SLOT_W-1:0] slot_data,
    input  logic                        ext_v_bit,
    input  logic                        int_err,
    output logic                        smp_stb,
    output logic [SLOT_W-1:0]           left_data,
    output logic                        left_valid,
    output logic [SLOT_W-1:0]           right_data,
    output logic                        right_valid,
    output logic                        spdif_oe,
    output logic                        ctl_wr_ok
);

    localparam int NCH = 2;

    logic              out_en;
    pair_sel_t         pair;
    logic              pad_mode;
    logic              strap_locked;
    logic [SLOT_W-1:0] ch_data [NCH];
    logic              ch_tag  [NCH];
    logic [SLOT_W-1:0] ch_word [NCH];
    logic              ch_flag [NCH];

    xac_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .codec_id (codec_id),
        .strap_in (strap_in),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .v_bit    (ext_v_bit),
        .rd_data  (rd_data),
        .out_en   (out_en),
        .pair     (pair),
        .pad_mode (pad_mode),
        .locked   (strap_locked)
    );

    slot_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_pick (
        .pair      (pair),
        .slot_tag  (slot_tag),
        .slot_data (slot_data),
        .l_data    (ch_data[0]),
        .l_tag     (ch_tag[0]),
        .r_data    (ch_data[1]),
        .r_tag     (ch_tag[1])
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        subframe_fmt #(.SLOT_W(SLOT_W)) u_fmt (
            .v_bit    (ext_v_bit),
            .pad_mode (pad_mode),
            .int_err  (int_err),
            .tag      (ch_tag[c]),
            .data_in  (ch_data[c]),
            .word     (ch_word[c]),
            .vflag    (ch_flag[c])
        );
    end

    // Capture routed samples at frame end and raise the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_stb     <= 1'b0;
            left_data   <= '0;
            left_valid  <= 1'b0;
            right_data  <= '0;
            right_valid <= 1'b0;
        end else begin
            smp_stb <= frame_end;
            if (frame_end) begin
                left_data   <= ch_word[0];
                left_valid  <= ch_flag[0];
                right_data  <= ch_word[1];
                right_valid <= ch_flag[1];
            end
        end
    end

    // Output enable and control-register write permit.
    always_comb begin
        spdif_oe  = out_en;
        ctl_wr_ok = ~out_en;
    end

endmodule

// File: rtl/spdif_slot_router_chk.sv
// Checker for spdif_slot_router, attached by bind below.
// Assumes: sees the top's ports plus its internal strap lock.
module spdif_slot_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_end,
    input logic        smp_stb,
    input logic        spdif_oe,
    input logic        ctl_wr_ok,
    input logic [15:0] rd_data,
    input logic        left_valid,
    input logic        right_valid,
    input logic        ext_v_bit,
    input logic        strap_locked
);

    AST_STB_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> smp_stb); // R11

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && !frame_end |=> !smp_stb); // R11

    AST_PERMIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        spdif_oe |-> !ctl_wr_ok); // R5

    AST_LOCK_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        strap_locked |-> (rd_data[15:1] == 15'd0)); // R3

    AST_LOCK_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        strap_locked |-> !spdif_oe); // R3

    AST_CFG_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[5] |-> spdif_oe); // R10

    AST_NO_V_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        smp_stb && !$past(ext_v_bit) |-> !left_valid && !right_valid); // R7

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[15:6] == 10'd0); // R2

endmodule

bind spdif_slot_router spdif_slot_router_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_end    (frame_end),
    .smp_stb      (smp_stb),
    .spdif_oe     (spdif_oe),
    .ctl_wr_ok    (ctl_wr_ok),
    .rd_data      (rd_data),
    .left_valid   (left_valid),
    .right_valid  (right_valid),
    .ext_v_bit    (ext_v_bit),
    .strap_locked (strap_locked)
);

// File: tb/spdif_slot_router_tb.sv
// Bench: vector table over modes and pairs, then directed reset/strap tests.
module spdif_slot_router_tb;

    localparam int NUM_SLOTS = 13;
    localparam int SLOT_W    = 20;
    localparam int NVEC      = 10;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic [1:0]                  codec_id = 2'b00;
    logic                        strap_in = 1'b0;
    logic                        wr_en = 1'b0;
    logic [15:0]                 wr_data = '0;
    logic [15:0]                 rd_data;
    logic                        frame_end = 1'b0;
    logic [NUM_SLOTS-1:0]        slot_tag = '0;
    logic [NUM_SLOTS*SLOT_W-1:0] slot_data = '0;
    logic                        ext_v_bit = 1'b0;
    logic                        int_err = 1'b0;
    logic                        smp_stb;
    logic [SLOT_W-1:0]           left_data;
    logic                        left_valid;
    logic [SLOT_W-1:0]           right_data;
    logic                        right_valid;
    logic                        spdif_oe;
    logic                        ctl_wr_ok;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    spdif_slot_router #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .codec_id(codec_id), .strap_in(strap_in),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .frame_end(frame_end), .slot_tag(slot_tag), .slot_data(slot_data),
        .ext_v_bit(ext_v_bit), .int_err(int_err), .smp_stb(smp_stb),
        .left_data(left_data), .left_valid(left_valid),
        .right_data(right_data), .right_valid(right_valid),
        .spdif_oe(spdif_oe), .ctl_wr_ok(ctl_wr_ok)
    );

    // Vector fields: [10:9] pair, [8] V, [7] pad mode, [6] int_err,
    // [5] left tag, [4] right tag, [3] exp left flag, [2] exp right flag,
    // [1] exp left zero, [0] exp right zero.
    localparam logic [10:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
        {2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R6
        {2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
        {2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R7
        {2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7
        {2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R7
        {2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}, // R9
        {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R9
        {2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
        {2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}  // R6
    };

    function automatic int exp_left(input logic [1:0] p);
        case (p)
            2'd0: return 3;
            2'd1: return 7;
            2'd2: return 6;
            default: return 10;
        endcase
    endfunction

    function automatic int exp_right(input logic [1:0] p);
        case (p)
            2'd0: return 4;
            2'd1: return 8;
            2'd2: return 9;
            default: return 11;
        endcase
    endfunction

    function automatic logic [SLOT_W-1:0] pattern(input int k, input int idx);
        return {k[3:0], idx[7:0], 8'h5A};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] cid, input logic strap);
        @(negedge clk);
        rst_n = 1'b0; codec_id = cid; strap_in = strap;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);   // strap sampled at the edge before this point
        strap_in = 1'b0;
    endtask

    task automatic reg_write(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_frame(input int idx, input logic [1:0] p,
                              input logic tl, input logic tr);
        for (int k = 0; k < NUM_SLOTS; k++)
            slot_data[k*SLOT_W +: SLOT_W] = pattern(k, idx);
        slot_tag = '1;
        slot_tag[exp_left(p)]  = tl;
        slot_tag[exp_right(p)] = tr;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [SLOT_W-1:0] held;

        // Reset state under each codec ID (R2, R4, R5).
        for (int id = 0; id < 4; id++) begin
            logic [1:0] exp_sel;
            exp_sel = (id == 0) ? 2'b01 : (id == 3) ? 2'b11 : 2'b10;
            do_reset(2'(id), 1'b0);
            chk("R2", "reset readback", 32'(rd_data), 32'({12'd0, exp_sel, 2'b00}));
            chk("R4", "reset oe", 32'(spdif_oe), 32'd0);
            chk("R5", "reset permit", 32'(ctl_wr_ok), 32'd1);
            chk("R11", "reset strobe", 32'(smp_stb), 32'd0);
        end

        // Vector walk over pairs and validity modes (R1, R6..R10, R11).
        for (int i = 0; i < NVEC; i++) begin
            logic [10:0] v;
            logic [SLOT_W-1:0] el, er;
            v = VEC[i];
            ext_v_bit = v[8];
            int_err   = v[6];
            reg_write({11'd0, v[7], v[10:9], 1'b1, 1'b0});
            chk("R10", "cfg status", 32'(rd_data[5]), 32'(!(v[8] && v[7])));
            chk("R4", "oe on", 32'(spdif_oe), 32'd1);
            chk("R5", "permit off", 32'(ctl_wr_ok), 32'd0);
            load_frame(i, v[10:9], v[5], v[4]);
            el = v[1] ? '0 : pattern(exp_left(v[10:9]), i);
            er = v[0] ? '0 : pattern(exp_right(v[10:9]), i);
            pulse_frame();
            chk("R11", "strobe", 32'(smp_stb), 32'd1);
            chk("R1", "left word", 32'(left_data), 32'(el));
            chk("R1", "right word", 32'(right_data), 32'(er));
            chk("R6", "left flag", 32'(left_valid), 32'(v[3]));
            chk("R7", "right flag", 32'(right_valid), 32'(v[2]));
        end

        // Strobe lasts one cycle and the outputs hold (R11).
        held = left_data;
        slot_data = '0;
        @(negedge clk);
        chk("R11", "strobe drop", 32'(smp_stb), 32'd0);
        chk("R11", "hold left", 32'(left_data), 32'(held));

        // Status bit ignores writes (R10).
        ext_v_bit = 1'b0;
        reg_write(16'h0020);
        chk("R10", "cfg not writable", 32'(rd_data[5]), 32'd0);
        chk("R5", "permit back", 32'(ctl_wr_ok), 32'd1);

        // Strap lock (R3).
        do_reset(2'b11, 1'b1);
        chk("R3", "locked readback", 32'(rd_data), 32'd0);
        reg_write(16'hFFFF);
        chk("R3", "locked write", 32'(rd_data), 32'h0001);
        chk("R3", "locked oe", 32'(spdif_oe), 32'd0);
        reg_write(16'h0000);
        chk("R3", "rate bit clears", 32'(rd_data), 32'd0);

        // Strap released at next reset (R3).
        do_reset(2'b00, 1'b0);
        reg_write(16'h000E);
        chk("R3", "unlocked write", 32'(rd_data), 32'h002E);

        done = 1'b1;
        finish_run();
    end

endmodule